// File: doc/BRIEF.md
# Dual-Slot Receive Buffer Controller

This block holds the control and status state of a simple Ethernet MAC. The MAC has two receive slots and one transmit slot, and each slot is backed by a 2048-byte buffer that lives outside this block. Software arms a receive slot by writing the "armed" code into that slot's state word. When the upstream receiver reports a finished frame, the block picks an armed slot and records the frame's stored length in that slot's count word. It then marks the slot as holding a frame. A level interrupt stays high as long as any slot holds a frame, so software clears the interrupt by rewriting the state words.

To transmit, software writes the frame length into the transmit count word. One cycle later the block checks the length window and the 8-byte header at the start of the transmit buffer. If both pass, it issues a one-cycle start pulse together with the payload length and clears the count word. It pulses the transmit interrupt whether the request passed or failed. The block also drives the PHY reset line and the bit-banged management lines from two of its words. The movement of frame bytes and the CRC are handled elsewhere.

Top module: `mac_slot_ctrl`

## Requirements
- R1: After reset every register word reads 0, and `rx_irq`, `rx_ready`, `tx_irq`, `tx_start` and `phy_rst` are low.
- R2: The word map is: 0 setup, 1 management, 2 slot-0 state, 3 slot-0 count, 4 slot-1 state, 5 slot-1 count, 6 transmit count. Setup keeps all 32 bits, and its bit 0 drives `phy_rst`. A state word keeps bits 1:0. A count word keeps bits 11:0. Word 7 reads 0.
- R3: Management word bits 0, 2 and 3 drive `mdio_do`, `mdio_oe` and `mdio_clk`. Bit 1 always reads the `mdio_di` input, and writes to bit 1 are ignored.
- R4: A slot state of 1 means armed, 2 means holding a frame, and 0 means empty. A frame goes to slot 0 when slot 0 is armed; otherwise it goes to slot 1 when slot 1 is armed.
- R5: A frame that arrives while no slot is armed is dropped. No state word or count word changes.
- R6: An accepted frame of payload length L sets its slot's state to 2 and its count to max(L, 60) + 12. Both values are readable right after the clock edge on which `rx_frame_valid` was sampled.
- R7: A frame with L + 12 greater than 2048 is dropped, and its slot stays armed. L = 2036 is accepted with a count of 2048.
- R8: `rx_irq` is high exactly while at least one state word equals 2. It follows software writes to the state words.
- R9: `rx_ready` is high exactly while at least one state word equals 1.
- R10: A transmit request is a nonzero write to word 6 whose value N lies between 64 and 1530 inclusive, where `tx_head` (byte 0 in bits 7:0) holds seven 0x55 bytes followed by 0xD5. One cycle after the write, such a request raises `tx_start` for one cycle with `tx_len` = N − 12, and word 6 then reads 0.
- R11: A request below 64, above 1530, or with any other header gives no `tx_start`, and word 6 keeps N.
- R12: Every nonzero write to word 6 raises `tx_irq` for exactly one cycle, in the cycle after the write. A zero write raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mdio_di | input | 1 | Management data from the PHY |
| rx_frame_valid | input | 1 | One-cycle strobe: a received frame is complete |
| rx_frame_len | input | 16 | Payload length of that frame in bytes |
| tx_head | input | 64 | First 8 bytes of the transmit buffer, byte 0 in bits 7:0 |
| rx_ready | output | 1 | At least one slot is armed |
| rx_take | output | 1 | The strobed frame is accepted this cycle |
| rx_slot | output | 1 | Slot that takes the frame |
| rx_irq | output | 1 | Level: a slot holds a frame |
| tx_start | output | 1 | One-cycle start of a valid transmit |
| tx_len | output | 16 | Bytes to send, starting at buffer offset 8 |
| tx_irq | output | 1 | One-cycle transmit completion pulse |
| phy_rst | output | 1 | PHY reset control |
| mdio_clk | output | 1 | Management clock |
| mdio_oe | output | 1 | Management data output enable |
| mdio_do | output | 1 | Management data out |

## Verification
Register writes and accepted frames change the register words on the same clock edge that samples them. `rx_irq` and `rx_ready` are decoded combinationally from those words, so the bench reads them at the falling edge right after the strobe. Transmit results arrive one registered stage later: `tx_irq`, `tx_start` and the clearing of word 6 all appear in the cycle after the write. The bench's driver queues one expected outcome per nonzero write. A monitor compares that outcome on every falling edge where `tx_irq` is high, so a pulse that comes early, late, is repeated or is missing leaves the queue mismatched.

// File: rtl/msc_pkg.sv
`timescale 1ns/1ps
package msc_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 3;
  localparam int A_SETUP     = 0;
  localparam int A_MDIO      = 1;
  localparam int A_SLOT_BASE = 2;
  localparam int FRAME_OVH   = 12;
  localparam int MIN_PAYLOAD = 60;
  localparam int HDR_BYTES   = 8;

  localparam logic [1:0] SLOT_EMPTY = 2'd0;
  localparam logic [1:0] SLOT_ARMED = 2'd1;
  localparam logic [1:0] SLOT_FULL  = 2'd2;

  localparam logic [7:0] HDR_FILL  = 8'h55;
  localparam logic [7:0] HDR_DELIM = 8'hD5;
endpackage

// File: rtl/msc_rx_arbiter.sv
`timescale 1ns/1ps
module msc_rx_arbiter
  import msc_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 12,
  parameter int BUF_BYTES = 2048,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0][1:0] slot_st,
  input  logic                      frame_valid,
  input  logic [LEN_W-1:0]          frame_len,
  output logic                      take,
  output logic [SEL_W-1:0]          sel,
  output logic [CNT_W-1:0]          total,
  output logic                      ready
);
  localparam logic [LEN_W:0] OVH_X = (LEN_W+1)'(FRAME_OVH);
  localparam logic [LEN_W:0] BUF_X = (LEN_W+1)'(BUF_BYTES);
  localparam logic [LEN_W:0] PAD_X = (LEN_W+1)'(MIN_PAYLOAD);

  logic [NUM_SLOTS-1:0] armed;
  logic                 found;
  logic [LEN_W:0]       len_x;
  logic [LEN_W:0]       padded;
  logic [LEN_W:0]       stored;
  logic                 fits;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_armed
    assign armed[g] = (slot_st[g] == SLOT_ARMED);
  end

  // lowest armed index wins
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (armed[i] && !found) begin
        sel   = SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    len_x  = {1'b0, frame_len};
    fits   = (len_x + OVH_X) <= BUF_X;
    padded = (len_x < PAD_X) ? PAD_X : len_x;
    stored = padded + OVH_X;
    total  = stored[CNT_W-1:0];
  end

  assign ready = |armed;
  assign take  = frame_valid && ready && fits;
endmodule

// File: rtl/msc_tx_checker.sv
`timescale 1ns/1ps
module msc_tx_checker
  import msc_pkg::*;
#(
  parameter int DATA_W_P = 32,
  parameter int LEN_W    = 16,
  parameter int TX_MIN   = 64,
  parameter int TX_MAX   = 1530
) (
  input  logic [DATA_W_P-1:0]    count,
  input  logic [8*HDR_BYTES-1:0] head,
  output logic                   ok,
  output logic [LEN_W-1:0]       payload_len
);
  logic [HDR_BYTES-1:0] byte_hit;
  logic                 len_ok;
  logic [DATA_W_P-1:0]  diff;

  for (genvar b = 0; b < HDR_BYTES; b++) begin : g_hdr
    localparam logic [7:0] WANT = (b == HDR_BYTES-1) ? HDR_DELIM : HDR_FILL;
    assign byte_hit[b] = (head[8*b +: 8] == WANT);
  end

  always_comb begin
    len_ok      = (count >= DATA_W_P'(TX_MIN)) && (count <= DATA_W_P'(TX_MAX));
    ok          = len_ok && (&byte_hit);
    diff        = count - DATA_W_P'(FRAME_OVH);
    payload_len = diff[LEN_W-1:0];
  end
endmodule

// File: rtl/msc_regbank.sv
`timescale 1ns/1ps
module msc_regbank
  import msc_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int CNT_W     = 12,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TXC_A    = A_SLOT_BASE + 2*NUM_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  input  logic                      mdio_di,
  input  logic                      rx_take,
  input  logic [SEL_W-1:0]          rx_sel,
  input  logic [CNT_W-1:0]          rx_total,
  input  logic                      tx_clear,
  output logic [NUM_SLOTS-1:0][1:0] slot_st,
  output logic [DATA_W-1:0]         txcount,
  output logic                      setup_bit0,
  output logic [2:0]                mdio_lines
);
  logic [DATA_W-1:0] st_arr [NUM_SLOTS];
  logic [DATA_W-1:0] ct_arr [NUM_SLOTS];

  logic              setup_en, mdio_en, txc_en, txc_wr;
  logic [DATA_W-1:0] setup_q, txc_d, txc_q;
  logic [2:0]        mdio_d, mdio_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(A_SLOT_BASE + 2*g);
    localparam logic [ADDR_W-1:0] CT_A = ADDR_W'(A_SLOT_BASE + 2*g + 1);
    logic             hit, st_en, ct_en;
    logic [1:0]       st_d, st_q;
    logic [CNT_W-1:0] ct_d, ct_q;

    // an accepted frame overrides a software write in the same cycle
    always_comb begin
      hit   = rx_take && (rx_sel == SEL_W'(g));
      st_en = hit || (wr_en && (addr == ST_A));
      ct_en = hit || (wr_en && (addr == CT_A));
      st_d  = hit ? SLOT_FULL : wdata[1:0];
      ct_d  = hit ? rx_total  : wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
        ct_q <= '0;
      end else begin
        if (st_en) st_q <= st_d;
        if (ct_en) ct_q <= ct_d;
      end
    end

    assign slot_st[g] = st_q;
    assign st_arr[g]  = DATA_W'(st_q);
    assign ct_arr[g]  = DATA_W'(ct_q);
  end

  always_comb begin
    setup_en = wr_en && (addr == ADDR_W'(A_SETUP));
    mdio_en  = wr_en && (addr == ADDR_W'(A_MDIO));
    txc_wr   = wr_en && (addr == ADDR_W'(TXC_A));
    txc_en   = txc_wr || tx_clear;
    txc_d    = txc_wr ? wdata : '0;
    mdio_d   = {wdata[3], wdata[2], wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      mdio_q  <= '0;
      txc_q   <= '0;
    end else begin
      if (setup_en) setup_q <= wdata;
      if (mdio_en)  mdio_q  <= mdio_d;
      if (txc_en)   txc_q   <= txc_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_SETUP)) rdata = setup_q;
    if (addr == ADDR_W'(A_MDIO))
      rdata = {{(DATA_W-4){1'b0}}, mdio_q[2], mdio_q[1], mdio_di, mdio_q[0]};
    if (addr == ADDR_W'(TXC_A)) rdata = txc_q;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (addr == ADDR_W'(A_SLOT_BASE + 2*s))     rdata = st_arr[s];
      if (addr == ADDR_W'(A_SLOT_BASE + 2*s + 1)) rdata = ct_arr[s];
    end
  end

  assign txcount    = txc_q;
  assign setup_bit0 = setup_q[0];
  assign mdio_lines = mdio_q;
endmodule

// File: rtl/mac_slot_ctrl.sv
`timescale 1ns/1ps
module mac_slot_ctrl
  import msc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 2048,
  parameter int TX_MIN    = 64,
  parameter int TX_MAX    = 1530,
  localparam int NUM_SLOTS = 2,
  localparam int CNT_W     = $clog2(BUF_BYTES) + 1,
  localparam int SEL_W     = 1,
  localparam int TXC_A     = A_SLOT_BASE + 2*NUM_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [2:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   mdio_di,
  input  logic                   rx_frame_valid,
  input  logic [LEN_W-1:0]       rx_frame_len,
  input  logic [63:0]            tx_head,
  output logic                   rx_ready,
  output logic                   rx_take,
  output logic                   rx_slot,
  output logic                   rx_irq,
  output logic                   tx_start,
  output logic [LEN_W-1:0]       tx_len,
  output logic                   tx_irq,
  output logic                   phy_rst,
  output logic                   mdio_clk,
  output logic                   mdio_oe,
  output logic                   mdio_do
);
  logic [1:0]                rst_pipe;
  logic                      rst_int_n;
  logic [NUM_SLOTS-1:0][1:0] slot_st;
  logic [NUM_SLOTS-1:0]      full_vec;
  logic [CNT_W-1:0]          rx_total;
  logic [DATA_W-1:0]         txcount;
  logic [2:0]                mdio_lines;
  logic                      tx_ok;
  logic [LEN_W-1:0]          tx_payload;
  logic                      tx_clear;

  logic             go_d, go_q;
  logic             irq_d, irq_q;
  logic             start_d, start_q;
  logic [LEN_W-1:0] len_d, len_q;

  // reset asserts at once, leaves two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  msc_regbank #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .mdio_di    (mdio_di),
    .rx_take    (rx_take),
    .rx_sel     (rx_slot),
    .rx_total   (rx_total),
    .tx_clear   (tx_clear),
    .slot_st    (slot_st),
    .txcount    (txcount),
    .setup_bit0 (phy_rst),
    .mdio_lines (mdio_lines)
  );

  msc_rx_arbiter #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W), .CNT_W(CNT_W),
                   .BUF_BYTES(BUF_BYTES)) u_arb (
    .slot_st     (slot_st),
    .frame_valid (rx_frame_valid),
    .frame_len   (rx_frame_len),
    .take        (rx_take),
    .sel         (rx_slot),
    .total       (rx_total),
    .ready       (rx_ready)
  );

  msc_tx_checker #(.DATA_W_P(DATA_W), .LEN_W(LEN_W), .TX_MIN(TX_MIN),
                   .TX_MAX(TX_MAX)) u_txchk (
    .count       (txcount),
    .head        (tx_head),
    .ok          (tx_ok),
    .payload_len (tx_payload)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_full
    assign full_vec[g] = (slot_st[g] == SLOT_FULL);
  end
  assign rx_irq = |full_vec;

  // transmit: capture request, judge it one cycle later
  always_comb begin
    go_d     = reg_wr && (reg_addr == 3'(TXC_A)) && (reg_wdata != '0);
    irq_d    = go_q;
    start_d  = go_q && tx_ok;
    len_d    = start_d ? tx_payload : len_q;
    tx_clear = start_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      go_q    <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      len_q   <= '0;
    end else begin
      go_q    <= go_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      len_q   <= len_d;
    end
  end

  assign tx_irq   = irq_q;
  assign tx_start = start_q;
  assign tx_len   = len_q;
  assign mdio_do  = mdio_lines[0];
  assign mdio_oe  = mdio_lines[1];
  assign mdio_clk = mdio_lines[2];
endmodule

// File: rtl/msc_checker.sv
`timescale 1ns/1ps
module msc_checker #(
  parameter int NUM_SLOTS = 2,
  parameter int LEN_W     = 16,
  parameter int TX_MIN    = 64,
  parameter int TX_MAX    = 1530
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rx_frame_valid,
  input logic                      rx_take,
  input logic                      rx_ready,
  input logic                      rx_slot,
  input logic                      rx_irq,
  input logic [NUM_SLOTS-1:0][1:0] slot_st,
  input logic                      tx_irq,
  input logic                      tx_start,
  input logic [LEN_W-1:0]          tx_len
);
  localparam logic [LEN_W-1:0] LO = LEN_W'(TX_MIN - 12);
  localparam logic [LEN_W-1:0] HI = LEN_W'(TX_MAX - 12);

  assert_take_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> rx_ready);

  assert_drop_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_valid && !rx_ready) |-> !rx_take);

  assert_slot0_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && slot_st[0] == 2'd1) |-> (rx_slot == 1'b0));

  assert_irq_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> rx_irq);

  assert_start_has_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_irq);

  assert_len_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_len >= LO && tx_len <= HI));
endmodule

bind mac_slot_ctrl msc_checker #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W),
                                 .TX_MIN(TX_MIN), .TX_MAX(TX_MAX)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_frame_valid (rx_frame_valid),
  .rx_take        (rx_take),
  .rx_ready       (rx_ready),
  .rx_slot        (rx_slot),
  .rx_irq         (rx_irq),
  .slot_st        (slot_st),
  .tx_irq         (tx_irq),
  .tx_start       (tx_start),
  .tx_len         (tx_len)
);

// File: tb/sim_mac_slot_ctrl.sv
`timescale 1ns/1ps
module sim_mac_slot_ctrl;
  localparam logic [63:0] GOOD_HEAD = 64'hD555_5555_5555_5555;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdio_di;
  logic        rx_frame_valid;
  logic [15:0] rx_frame_len;
  logic [63:0] tx_head;
  logic        rx_ready, rx_take, rx_slot, rx_irq;
  logic        tx_start, tx_irq;
  logic [15:0] tx_len;
  logic        phy_rst, mdio_clk, mdio_oe, mdio_do;

  always #5 clk = ~clk;

  mac_slot_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_di(mdio_di),
    .rx_frame_valid(rx_frame_valid), .rx_frame_len(rx_frame_len),
    .tx_head(tx_head), .rx_ready(rx_ready), .rx_take(rx_take),
    .rx_slot(rx_slot), .rx_irq(rx_irq), .tx_start(tx_start),
    .tx_len(tx_len), .tx_irq(tx_irq), .phy_rst(phy_rst),
    .mdio_clk(mdio_clk), .mdio_oe(mdio_oe), .mdio_do(mdio_do)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  typedef struct packed { logic start; logic [15:0] len; } tx_exp_t;
  tx_exp_t exp_q[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, $sformatf("word %0d", a), reg_rdata, exp);
  endtask

  task automatic frame(input logic [15:0] len);
    @(negedge clk);
    rx_frame_valid = 1'b1; rx_frame_len = len;
    @(negedge clk);
    rx_frame_valid = 1'b0;
  endtask

  // driver: queue the expected outcome, then issue the write
  task automatic tx_req(input logic [31:0] n, input logic good);
    tx_exp_t e;
    e.start = good;
    e.len   = good ? 16'(n - 12) : 16'h0;
    exp_q.push_back(e);
    wr(3'd6, n);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare each tx_irq cycle against the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_start && !tx_irq) begin
        checks++; errors++;
        $display("FAIL R10 tx_start without tx_irq: actual=1 expected=0");
      end
      if (tx_irq) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected tx_irq: actual=1 expected=0");
        end else begin
          tx_exp_t e;
          e = exp_q.pop_front();
          if (tx_start !== e.start) begin
            errors++;
            $display("FAIL R10/R11 tx_start: actual=%0b expected=%0b", tx_start, e.start);
          end else if (e.start && tx_len !== e.len) begin
            errors++;
            $display("FAIL R10 tx_len: actual=%0d expected=%0d", tx_len, e.len);
          end
        end
      end
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report;
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mdio_di = 1'b0; rx_frame_valid = 1'b0; rx_frame_len = '0;
    tx_head = GOOD_HEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) rd_check("R1", 3'(a), 32'h0);
    check("R1", "rx_irq", rx_irq, 0);
    check("R1", "rx_ready", rx_ready, 0);
    check("R1", "tx_irq", tx_irq, 0);
    check("R1", "tx_start", tx_start, 0);
    check("R1", "phy_rst", phy_rst, 0);
    mon_on = 1'b1;

    // R2 register storage
    wr(3'd0, 32'hA5A5_0001);
    rd_check("R2", 3'd0, 32'hA5A5_0001);
    check("R2", "phy_rst", phy_rst, 1);
    wr(3'd0, 32'h0);
    check("R2", "phy_rst low", phy_rst, 0);
    wr(3'd3, 32'hFFFF_F123);
    rd_check("R2", 3'd3, 32'h123);
    wr(3'd3, 32'h0);
    rd_check("R2", 3'd7, 32'h0);

    // R3 management lines
    wr(3'd1, 32'hF);
    check("R3", "mdio_do", mdio_do, 1);
    check("R3", "mdio_oe", mdio_oe, 1);
    check("R3", "mdio_clk", mdio_clk, 1);
    rd_check("R3", 3'd1, 32'hD);
    mdio_di = 1'b1;
    rd_check("R3", 3'd1, 32'hF);
    wr(3'd1, 32'h2);
    rd_check("R3", 3'd1, 32'h2);
    check("R3", "mdio_clk off", mdio_clk, 0);
    mdio_di = 1'b0;
    rd_check("R3", 3'd1, 32'h0);

    // R5 drop when nothing armed
    frame(16'd100);
    rd_check("R5", 3'd2, 32'h0);
    rd_check("R5", 3'd4, 32'h0);
    rd_check("R5", 3'd3, 32'h0);
    rd_check("R5", 3'd5, 32'h0);
    check("R5", "rx_irq", rx_irq, 0);

    // R9, R4: only slot 1 armed
    wr(3'd4, 32'h1);
    check("R9", "rx_ready", rx_ready, 1);
    frame(16'd100);
    rd_check("R4", 3'd4, 32'h2);
    rd_check("R6", 3'd5, 32'd112);
    rd_check("R4", 3'd2, 32'h0);
    check("R8", "rx_irq high", rx_irq, 1);
    check("R9", "rx_ready low", rx_ready, 0);

    // R4 priority with both armed, R6 padding
    wr(3'd4, 32'h1);
    wr(3'd2, 32'h1);
    check("R8", "rx_irq after rearm", rx_irq, 0);
    frame(16'd30);
    rd_check("R4", 3'd2, 32'h2);
    rd_check("R6", 3'd3, 32'd72);
    rd_check("R4", 3'd4, 32'h1);
    frame(16'd61);
    rd_check("R4", 3'd4, 32'h2);
    rd_check("R6", 3'd5, 32'd73);
    frame(16'd500);
    rd_check("R5", 3'd3, 32'd72);
    rd_check("R5", 3'd5, 32'd73);

    // R8 level follows software
    wr(3'd2, 32'h0);
    check("R8", "rx_irq one left", rx_irq, 1);
    wr(3'd4, 32'h0);
    check("R8", "rx_irq cleared", rx_irq, 0);

    // R7 buffer limit
    wr(3'd2, 32'h1);
    frame(16'd2037);
    rd_check("R7", 3'd2, 32'h1);
    rd_check("R7", 3'd3, 32'd72);
    frame(16'd2036);
    rd_check("R7", 3'd2, 32'h2);
    rd_check("R7", 3'd3, 32'd2048);
    wr(3'd2, 32'h0);

    // R10 valid transmits
    tx_req(32'd100, 1'b1);
    rd_check("R10", 3'd6, 32'h0);
    tx_req(32'd64, 1'b1);
    tx_req(32'd1530, 1'b1);
    rd_check("R10", 3'd6, 32'h0);

    // R11 rejections
    tx_req(32'd63, 1'b0);
    rd_check("R11", 3'd6, 32'd63);
    tx_req(32'd1531, 1'b0);
    rd_check("R11", 3'd6, 32'd1531);
    tx_head = 64'hD555_5555_5555_5554;
    tx_req(32'd200, 1'b0);
    rd_check("R11", 3'd6, 32'd200);
    tx_head = 64'h5555_5555_5555_5555;
    tx_req(32'd200, 1'b0);
    tx_head = GOOD_HEAD;

    // R12 zero write raises nothing; queue fully consumed
    wr(3'd6, 32'h0);
    repeat (4) @(negedge clk);
    rd_check("R12", 3'd6, 32'h0);
    check("R12", "pending tx outcomes", 32'(exp_q.size()), 32'h0);

    report;
    $finish;
  end
endmodule